// File: doc/BRIEF.md
# DDR Read Data Serializer with Prefetch Pairs

This block is the read side of a double-data-rate memory device's data path. When a READ command is accepted on a rising clock edge, it starts an internal column access to a behavioural memory core. The core returns a word that is twice the external data width. After the programmed CAS latency, that word leaves the block as two external words in a single clock cycle: the first in the high phase of the clock and the second in the low phase. A strobe travels with the data, driven by the device.

One READ starts a burst of `BURST_PAIRS` internal fetches. Columns advance by wrapping inside the aligned group of `BURST_PAIRS` columns. A new READ ends the running burst and starts a fresh one at once, so READs on consecutive cycles give an unbroken stream of pairs. A BURST TERMINATE command cancels every fetch that has not been issued yet. Pairs already fetched still drain. There is no output enable or mask on the read side.

Each cycle's outputs are given as a value for each half-cycle (rise phase and fall phase), ready for a double-rate output register at the pads. The strobe has a low preamble before the first data cycle. After the last data cycle it has a half-cycle low postamble and is then released.

Top module: `ddr_read_serializer`

## Requirements
- R1: While `rst` is high at a rising edge, no core fetch is requested, and in the following cycle every output enable is low and both data halves are zero.
- R2: A READ (cmd = 2'b01) sampled at a rising edge requests a core fetch in that same cycle, with the command's bank and column on `core_bank`/`core_col`.
- R3: The data of a fetch requested in cycle t is driven, with `dq_oe` high, in cycle t+CAS_LAT and in no other cycle.
- R4: The rise-phase word `dq_rise` carries the lower DATA_W bits of the fetched word. The fall-phase word `dq_fall` carries the upper DATA_W bits. Both slots are always filled.
- R5: With no new command (cmd = 2'b00, or the unused code 2'b11 treated as a no-op), a READ is followed by BURST_PAIRS-1 more fetches on the next cycles. Each uses the READ's bank, and its column is the previous column plus one, wrapped inside the aligned group of BURST_PAIRS columns (BURST_PAIRS a power of two).
- R6: A READ that arrives while a burst is still fetching drops that burst's remaining fetches and fetches its own column in the same cycle, so READs on consecutive cycles produce data on consecutive cycles with no idle cycle between them.
- R7: A BURST TERMINATE (cmd = 2'b10) requests no fetch and cancels every fetch not yet issued. Pairs fetched before it still appear on the bus.
- R8: In every data cycle the strobe is driven in both phases: high in the rise phase and low in the fall phase.
- R9: In a cycle without data that is followed by a data cycle, the strobe is driven low in both phases (preamble).
- R10: In a cycle without data that follows a data cycle and is not a preamble, the strobe is driven low in the rise phase and released in the fall phase (postamble).
- R11: In any other cycle without data, the data and strobe enables are low, and both data halves stay zero in every cycle without data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; commands are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command code: 00 no-op, 01 READ, 10 BURST TERMINATE, 11 no-op |
| cmd_bank | input | BANK_W | Bank of a READ |
| cmd_col | input | COL_W | Column of a READ, in units of 2·DATA_W-bit words |
| core_rd | output | 1 | Core fetch request for this cycle |
| core_bank | output | BANK_W | Bank of the fetch |
| core_col | output | COL_W | Column of the fetch |
| core_rdata | input | 2*DATA_W | Core word for the requested location, valid in the same cycle |
| dq_rise | output | DATA_W | Data word for the rise phase of the cycle |
| dq_fall | output | DATA_W | Data word for the fall phase of the cycle |
| dq_oe | output | 1 | Data bus driven during this cycle |
| dqs_rise | output | 1 | Strobe level in the rise phase |
| dqs_fall | output | 1 | Strobe level in the fall phase |
| dqs_oe_rise | output | 1 | Strobe driven in the rise phase |
| dqs_oe_fall | output | 1 | Strobe driven in the fall phase |

## Verification
The assertions check the following every cycle:
- READ and terminate map onto the core fetch request.
- Each data cycle lies exactly CAS_LAT cycles after a fetch.
- The strobe waveform is correct in data, preamble and postamble cycles.
- The bus is quiet when there is no data, including right after reset.

Some behaviour depends on the data and can only be shown by the bench's scenarios. This covers which half of the core word lands in which phase, the column wrap inside a burst, the restart of a burst by a new READ, and the exact pairs that survive a BURST TERMINATE. The bench checks these against its own model of the fetch schedule and the core contents, using both directed sequences and weighted random command streams.

// File: rtl/rdser_pkg.sv
package rdser_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_TERM  = 2'b10,
        CMD_SPARE = 2'b11
    } rd_cmd_e;

    // Strobe drive for one clock cycle, split into its two phases.
    typedef struct packed {
        logic oe_r;
        logic lvl_r;
        logic oe_f;
        logic lvl_f;
    } dqs_drive_t;

    localparam dqs_drive_t DQS_IDLE  = '{oe_r: 1'b0, lvl_r: 1'b0, oe_f: 1'b0, lvl_f: 1'b0};
    localparam dqs_drive_t DQS_DATA  = '{oe_r: 1'b1, lvl_r: 1'b1, oe_f: 1'b1, lvl_f: 1'b0};
    localparam dqs_drive_t DQS_PRE   = '{oe_r: 1'b1, lvl_r: 1'b0, oe_f: 1'b1, lvl_f: 1'b0};
    localparam dqs_drive_t DQS_POST  = '{oe_r: 1'b1, lvl_r: 1'b0, oe_f: 1'b0, lvl_f: 1'b0};

    // Select the strobe pattern from data presence in the current,
    // following and preceding cycles.
    function automatic dqs_drive_t dqs_pattern(input logic cur, input logic nxt, input logic prv);
        dqs_drive_t d;
        if (cur) begin
            d = DQS_DATA;
        end else if (nxt) begin
            d = DQS_PRE;
        end else if (prv) begin
            d = DQS_POST;
        end else begin
            d = DQS_IDLE;
        end
        return d;
    endfunction

    // Next column inside an aligned group of 'group' columns (power of two).
    function automatic int unsigned wrap_next_col(input int unsigned col, input int unsigned group);
        int unsigned base;
        base = (col / group) * group;
        return base + ((col + 1) % group);
    endfunction

endpackage

// File: rtl/rdser_fetch_seq.sv
module rdser_fetch_seq
    import rdser_pkg::*;
#(
    parameter int BANK_W      = 2,
    parameter int COL_W       = 8,
    parameter int BURST_PAIRS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    output logic              fetch_o,
    output logic [BANK_W-1:0] fbank_o,
    output logic [COL_W-1:0]  fcol_o
);

    localparam int REM_W = $clog2(BURST_PAIRS + 1);
    localparam logic [REM_W-1:0] REM_RELOAD = REM_W'(BURST_PAIRS - 1);

    rd_cmd_e           cmd_e;
    logic [REM_W-1:0]  rem_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic              cont;

    assign cmd_e = rd_cmd_e'(cmd_i);
    assign cont  = (rem_q != '0);

    always_comb begin
        fetch_o = 1'b0;
        fbank_o = bank_q;
        fcol_o  = col_q;
        if (!rst) begin
            unique case (cmd_e)
                CMD_READ: begin
                    fetch_o = 1'b1;
                    fbank_o = bank_i;
                    fcol_o  = col_i;
                end
                CMD_TERM: begin
                    fetch_o = 1'b0;
                end
                default: begin
                    fetch_o = cont;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            bank_q <= '0;
            col_q  <= '0;
        end else begin
            unique case (cmd_e)
                CMD_READ: begin
                    rem_q  <= REM_RELOAD;
                    bank_q <= bank_i;
                    col_q  <= COL_W'(wrap_next_col(32'(col_i), BURST_PAIRS));
                end
                CMD_TERM: begin
                    rem_q <= '0;
                end
                default: begin
                    if (cont) begin
                        rem_q <= rem_q - 1'b1;
                        col_q <= COL_W'(wrap_next_col(32'(col_q), BURST_PAIRS));
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/rdser_lat_pipe.sv
module rdser_lat_pipe #(
    parameter int WORD_W  = 16,
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              next_valid,
    output logic              prev_valid
);

    logic [CAS_LAT-1:0] valid_q;
    logic [WORD_W-1:0]  data_q [CAS_LAT];
    logic               tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q[0] <= 1'b0;
            data_q[0]  <= '0;
        end else begin
            valid_q[0] <= in_valid;
            data_q[0]  <= in_valid ? in_data : '0;
        end
    end

    for (genvar s = 1; s < CAS_LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[s] <= 1'b0;
                data_q[s]  <= '0;
            end else begin
                valid_q[s] <= valid_q[s-1];
                data_q[s]  <= data_q[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q <= 1'b0;
        end else begin
            tail_q <= valid_q[CAS_LAT-1];
        end
    end

    assign out_valid  = valid_q[CAS_LAT-1];
    assign out_data   = data_q[CAS_LAT-1];
    assign next_valid = valid_q[CAS_LAT-2];
    assign prev_valid = tail_q;

endmodule

// File: rtl/rdser_strobe_gen.sv
module rdser_strobe_gen
    import rdser_pkg::*;
(
    input  logic cur_valid,
    input  logic next_valid,
    input  logic prev_valid,
    output logic dqs_rise,
    output logic dqs_fall,
    output logic dqs_oe_rise,
    output logic dqs_oe_fall
);

    dqs_drive_t drv;

    always_comb begin
        drv = dqs_pattern(cur_valid, next_valid, prev_valid);
    end

    assign dqs_rise    = drv.lvl_r;
    assign dqs_fall    = drv.lvl_f;
    assign dqs_oe_rise = drv.oe_r;
    assign dqs_oe_fall = drv.oe_f;

endmodule

// File: rtl/ddr_read_serializer.sv
module ddr_read_serializer
    import rdser_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int BANK_W      = 2,
    parameter int COL_W       = 8,
    parameter int CAS_LAT     = 2,
    parameter int BURST_PAIRS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          cmd,
    input  logic [BANK_W-1:0]   cmd_bank,
    input  logic [COL_W-1:0]    cmd_col,
    output logic                core_rd,
    output logic [BANK_W-1:0]   core_bank,
    output logic [COL_W-1:0]    core_col,
    input  logic [2*DATA_W-1:0] core_rdata,
    output logic [DATA_W-1:0]   dq_rise,
    output logic [DATA_W-1:0]   dq_fall,
    output logic                dq_oe,
    output logic                dqs_rise,
    output logic                dqs_fall,
    output logic                dqs_oe_rise,
    output logic                dqs_oe_fall
);

    localparam int WORD_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] upper;
        logic [DATA_W-1:0] lower;
    } pair_t;

    pair_t out_pair;
    logic  [WORD_W-1:0] out_word;
    logic  out_valid, next_valid, prev_valid;

    rdser_fetch_seq #(
        .BANK_W      (BANK_W),
        .COL_W       (COL_W),
        .BURST_PAIRS (BURST_PAIRS)
    ) fetch_i (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd),
        .bank_i  (cmd_bank),
        .col_i   (cmd_col),
        .fetch_o (core_rd),
        .fbank_o (core_bank),
        .fcol_o  (core_col)
    );

    rdser_lat_pipe #(
        .WORD_W  (WORD_W),
        .CAS_LAT (CAS_LAT)
    ) pipe_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (core_rd),
        .in_data    (core_rdata),
        .out_valid  (out_valid),
        .out_data   (out_word),
        .next_valid (next_valid),
        .prev_valid (prev_valid)
    );

    rdser_strobe_gen strobe_i (
        .cur_valid   (out_valid),
        .next_valid  (next_valid),
        .prev_valid  (prev_valid),
        .dqs_rise    (dqs_rise),
        .dqs_fall    (dqs_fall),
        .dqs_oe_rise (dqs_oe_rise),
        .dqs_oe_fall (dqs_oe_fall)
    );

    assign out_pair = pair_t'(out_word);
    assign dq_rise  = out_pair.lower;
    assign dq_fall  = out_pair.upper;
    assign dq_oe    = out_valid;

endmodule

// File: rtl/ddr_read_serializer_chk.sv
module ddr_read_serializer_chk #(
    parameter int DATA_W      = 8,
    parameter int BANK_W      = 2,
    parameter int COL_W       = 8,
    parameter int CAS_LAT     = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cmd,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [COL_W-1:0]  cmd_col,
    input logic              core_rd,
    input logic [BANK_W-1:0] core_bank,
    input logic [COL_W-1:0]  core_col,
    input logic [DATA_W-1:0] dq_rise,
    input logic [DATA_W-1:0] dq_fall,
    input logic              dq_oe,
    input logic              dqs_rise,
    input logic              dqs_fall,
    input logic              dqs_oe_rise,
    input logic              dqs_oe_fall
);

    // History of fetch requests, one bit per cycle of latency.
    logic [CAS_LAT-1:0] fetch_hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_hist <= '0;
        end else begin
            fetch_hist <= {fetch_hist[CAS_LAT-2:0], core_rd};
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!dq_oe && !dqs_oe_rise && !dqs_oe_fall && dq_rise == '0 && dq_fall == '0));

    assert_read_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'b01) |-> (core_rd && core_bank == cmd_bank && core_col == cmd_col));

    assert_cas_latency_R3: assert property (@(posedge clk) disable iff (rst)
        dq_oe == fetch_hist[CAS_LAT-1]);

    assert_term_no_fetch_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'b10) |-> !core_rd);

    assert_strobe_toggle_R8: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (dqs_oe_rise && dqs_oe_fall && dqs_rise && !dqs_fall));

    assert_preamble_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> $past(dqs_oe_rise && dqs_oe_fall && !dqs_rise && !dqs_fall));

    assert_postamble_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(dq_oe) |-> (dqs_oe_rise && !dqs_rise && !dqs_fall));

    assert_quiet_bus_R11: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> (dq_rise == '0 && dq_fall == '0));

endmodule

bind ddr_read_serializer ddr_read_serializer_chk #(
    .DATA_W  (DATA_W),
    .BANK_W  (BANK_W),
    .COL_W   (COL_W),
    .CAS_LAT (CAS_LAT)
) chk_i (.*);

// File: tb/ddr_read_serializer_tb_top.sv
module ddr_read_serializer_tb_top;

    localparam int DW = 8;
    localparam int BW = 2;
    localparam int CW = 8;
    localparam int CL = 2;
    localparam int BP = 2;
    localparam int RING = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cmd = 2'b00;
    logic [BW-1:0] cmd_bank = '0;
    logic [CW-1:0] cmd_col = '0;
    logic          core_rd;
    logic [BW-1:0] core_bank;
    logic [CW-1:0] core_col;
    logic [2*DW-1:0] core_rdata;
    logic [DW-1:0] dq_rise, dq_fall;
    logic          dq_oe, dqs_rise, dqs_fall, dqs_oe_rise, dqs_oe_fall;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int ref_rem = 0;
    int ref_bank = 0;
    int ref_col = 0;
    logic            ev [RING];
    logic [2*DW-1:0] ed [RING];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [2*DW-1:0] mem_word(input int b, input int c);
        logic [DW-1:0] lo, hi;
        lo = DW'(c * 7 + b * 61 + 3);
        hi = DW'((c * 11) ^ (b * 37) ^ 165);
        return {hi, lo};
    endfunction

    function automatic int col_after(input int c);
        return (c & ~(BP - 1)) | ((c + 1) & (BP - 1));
    endfunction

    assign core_rdata = mem_word(int'(core_bank), int'(core_col));

    ddr_read_serializer #(
        .DATA_W(DW), .BANK_W(BW), .COL_W(CW), .CAS_LAT(CL), .BURST_PAIRS(BP)
    ) dut_i (
        .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .core_rd(core_rd), .core_bank(core_bank), .core_col(core_col),
        .core_rdata(core_rdata), .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe),
        .dqs_rise(dqs_rise), .dqs_fall(dqs_fall),
        .dqs_oe_rise(dqs_oe_rise), .dqs_oe_fall(dqs_oe_fall)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic check_outputs(input bit in_reset);
        int idx;
        logic v, nv, pv;
        logic [2*DW-1:0] d;
        logic [3:0] es;
        string stag;
        idx = cyc % RING;
        v  = ev[idx];
        d  = ed[idx];
        nv = ev[(cyc + 1) % RING];
        pv = ev[(cyc + RING - 1) % RING];
        if (in_reset) begin
            chk("R1", "quiet outputs in reset",
                64'({dq_oe, dqs_oe_rise, dqs_oe_fall, dq_rise, dq_fall}), 64'(0));
        end else begin
            chk("R3", "dq_oe", 64'(dq_oe), 64'(v));
            if (v) begin
                chk("R4", "rise/fall words", 64'({dq_fall, dq_rise}), 64'(d));
                es = 4'b1110; stag = "R8";
            end else begin
                chk("R11", "idle data zero", 64'({dq_fall, dq_rise}), 64'(0));
                if (nv) begin
                    es = 4'b1010; stag = "R9";
                end else if (pv) begin
                    es = 4'b1000; stag = "R10";
                end else begin
                    es = 4'b0000; stag = "R11";
                end
            end
            // order: oe_rise, level_rise, oe_fall, level_fall
            chk(stag, "strobe {oe_r,lvl_r,oe_f,lvl_f}",
                64'({dqs_oe_rise, dqs_rise, dqs_oe_fall, dqs_fall}), 64'(es));
        end
        ev[(cyc + RING - 2) % RING] = 1'b0;
    endtask

    task automatic step(input logic r, input logic [1:0] c, input int b, input int col);
        bit f;
        int fb, fc, idx;
        string tag;
        check_outputs(rst);
        rst = r;
        cmd = c;
        cmd_bank = BW'(b);
        cmd_col = CW'(col);
        #1;
        f = 1'b0; fb = 0; fc = 0;
        if (r) begin
            tag = "R1"; ref_rem = 0;
        end else if (c == 2'b01) begin
            tag = (ref_rem > 0) ? "R6" : "R2";
            f = 1'b1; fb = b; fc = col;
            ref_rem = BP - 1; ref_bank = b; ref_col = col_after(col);
        end else if (c == 2'b10) begin
            tag = "R7"; ref_rem = 0;
        end else if (ref_rem > 0) begin
            tag = "R5";
            f = 1'b1; fb = ref_bank; fc = ref_col;
            ref_rem--; ref_col = col_after(ref_col);
        end else begin
            tag = "R11";
        end
        chk(tag, "core_rd", 64'(core_rd), 64'(f));
        if (f) begin
            chk(tag, "core bank/col", 64'({core_bank, core_col}), 64'({BW'(fb), CW'(fc)}));
            idx = (cyc + CL) % RING;
            ev[idx] = 1'b1;
            ed[idx] = mem_word(fb, fc);
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        total++;
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < RING; i++) begin
            ev[i] = 1'b0;
            ed[i] = '0;
        end
        void'($urandom(32'h5EED_1234));
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 4; i++) step(1'b1, 2'b01, 1, 9);
        for (int i = 0; i < 3; i++) step(1'b0, 2'b00, 0, 0);

        // R5: single READ at odd column, burst wraps inside its pair group
        step(1'b0, 2'b01, 1, 5);
        for (int i = 0; i < 5; i++) step(1'b0, 2'b00, 0, 0);

        // R6: back-to-back READs give a gapless stream
        step(1'b0, 2'b01, 0, 10);
        step(1'b0, 2'b01, 2, 20);
        step(1'b0, 2'b01, 3, 31);
        for (int i = 0; i < 5; i++) step(1'b0, 2'b00, 0, 0);

        // R7: terminate right after READ, only the first pair survives
        step(1'b0, 2'b01, 2, 8);
        step(1'b0, 2'b10, 0, 0);
        for (int i = 0; i < 5; i++) step(1'b0, 2'b00, 0, 0);

        // R9/R10: one idle cycle between two data cycles is a full-low preamble
        step(1'b0, 2'b01, 1, 40);
        step(1'b0, 2'b10, 0, 0);
        step(1'b0, 2'b01, 1, 50);
        step(1'b0, 2'b10, 0, 0);
        for (int i = 0; i < 5; i++) step(1'b0, 2'b00, 0, 0);

        // R5: spare code acts as a no-op and lets the burst continue
        step(1'b0, 2'b01, 3, 254);
        step(1'b0, 2'b11, 0, 0);
        for (int i = 0; i < 5; i++) step(1'b0, 2'b00, 0, 0);

        // weighted random command streams
        for (int i = 0; i < 3000; i++) begin
            int p;
            logic [1:0] c;
            p = int'($urandom_range(99));
            if (p < 45) c = 2'b01;
            else if (p < 55) c = 2'b10;
            else if (p < 62) c = 2'b11;
            else c = 2'b00;
            step(1'b0, c, int'($urandom_range(3)), int'($urandom_range(255)));
        end
        for (int i = 0; i < 6; i++) step(1'b0, 2'b00, 0, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule